// File: doc/BRIEF.md
# Multi-Modulus Triple Generator

This combinational unit forms three times an n-bit residue, reduced by one of three moduli picked by a 2-bit select: 2^n-1, 2^n or 2^n+1. It is meant to feed the partial-product stage of a radix-8 multiplier that shares one datapath across the three channels of a residue number system. The sum is X plus the modular double of X. The doubled operand is never built as a word of its own. Each bit position derives its generate, propagate and sum terms straight from x_i and x_{i-1}. Only bit 0 gets the wrapped bit through a 3:1 select: unchanged, forced to zero or inverted.

Those terms feed one Kogge-Stone prefix tree, which is the same for every modulus. After the tree, the group generate across the whole word is turned into the carry into bit 0. For 2^n-1 it is fed back as is (end-around carry). For 2^n it is dropped. For 2^n+1 it is fed back inverted (complemented end-around carry), so a diminished-1 operand yields a diminished-1 result. The width n is a parameter with a default of 8.

Top module: `mm_hard_multiple`

## Requirements
- R1: With select code 01, the output equals 3X mod 2^n.
- R2: With select code 10, the output is congruent to 3X mod 2^n-1. An input of all ones is a valid second encoding of zero.
- R3: With select code 00, the input is diminished-1 (it encodes X+1). The output is the diminished-1 form of three times that value, which is (3X+2) mod (2^n+1) cut to its low n bits.
- R4: Select code 11 gives the same output as code 01 for every input.
- R5: An all-zero input gives 0 under code 01, 0 under code 10 and 2 under code 00.
- R6: An all-ones input gives 2^n-3 under codes 01 and 00, and all ones under code 10.
- R7: The unit holds no state. The output follows a change of input or select without any clock edge.
- R8: Under code 10, a zero result is all zeros only when the input is all zeros. A nonzero input whose triple is a multiple of 2^n-1 gives all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_res | input | N | Residue operand (binary for 2^n-1 and 2^n, diminished-1 for 2^n+1) |
| mod_sel | input | 2 | Modulus select: 00 = 2^n+1, 01 = 2^n, 10 = 2^n-1, 11 = same as 01 |
| hard_mult | output | N | Three times the operand, reduced by the selected modulus |

## Verification
Every operand is swept under all four select codes.

- **Wrap-bit select.** A swapped or missing bit-0 select shows up as a result off by one or by 2^n.
- **Carry-in choice.** If the inverted group generate is replaced by the plain one, the 2^n+1 channel goes wrong whenever the raw sum stays below 2^n. If the carry is leaked into the 2^n channel, its results come out one too high.
- **Mersenne multiples.** Inputs such as 85 and 170 at n = 8 sum to exactly all ones with no carry out. They show whether the all-ones zero encoding comes out instead of a spurious wrap.
- **Timing.** A mid-cycle input change shows whether any result waits for a clock.

// File: rtl/hmg_pkg.sv
package hmg_pkg;

    typedef enum logic [1:0] {
        SEL_DIM1 = 2'b00,
        SEL_POW2 = 2'b01,
        SEL_MERS = 2'b10,
        SEL_RSVD = 2'b11
    } modsel_e;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    function automatic gp_t gp_combine(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // bit that the modular double places at position 0
    function automatic logic wrap_pick(input modsel_e s, input logic top_bit);
        logic r;
        unique case (s)
            SEL_MERS: r = top_bit;
            SEL_DIM1: r = ~top_bit;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    // carry injected at bit 0 once the full-word generate is known
    function automatic logic cin_pick(input modsel_e s, input logic g_all);
        logic r;
        unique case (s)
            SEL_MERS: r = g_all;
            SEL_DIM1: r = ~g_all;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hmg_preproc.sv
module hmg_preproc
    import hmg_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]     x_i,
    input  modsel_e          sel_i,
    output gp_t  [N-1:0]     gp_o,
    output logic [N-1:0]     t_o
);
    logic wrap_bit;

    always_comb wrap_bit = wrap_pick(sel_i, x_i[N-1]);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic partner;
        if (i == 0) begin : g_lsb
            assign partner = wrap_bit;
        end else begin : g_upper
            assign partner = x_i[i-1];
        end
        assign gp_o[i].g = x_i[i] & partner;
        assign gp_o[i].p = x_i[i] | partner;
        assign t_o[i]    = x_i[i] ^ partner;
    end
endmodule

// File: rtl/hmg_prefix_tree.sv
module hmg_prefix_tree
    import hmg_pkg::*;
#(
    parameter int N = 8
) (
    input  gp_t [N-1:0] gp_i,
    output gp_t [N-1:0] grp_o
);
    localparam int LEVELS = (N > 1) ? $clog2(N) : 1;

    gp_t [LEVELS:0][N-1:0] stage;

    assign stage[0] = gp_i;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int SPAN = 1 << l;
        for (genvar i = 0; i < N; i++) begin : g_node
            if (i >= SPAN) begin : g_merge
                assign stage[l+1][i] = gp_combine(stage[l][i], stage[l][i-SPAN]);
            end else begin : g_pass
                assign stage[l+1][i] = stage[l][i];
            end
        end
    end

    assign grp_o = stage[LEVELS];
endmodule

// File: rtl/hmg_postproc.sv
module hmg_postproc
    import hmg_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] t_i,
    input  gp_t  [N-1:0] grp_i,
    input  modsel_e      sel_i,
    output logic [N-1:0] sum_o
);
    logic         cin;
    logic [N-1:0] carry;

    always_comb cin = cin_pick(sel_i, grp_i[N-1].g);

    for (genvar i = 0; i < N; i++) begin : g_carry
        if (i == 0) begin : g_first
            assign carry[i] = cin;
        end else begin : g_rest
            assign carry[i] = grp_i[i-1].g | (grp_i[i-1].p & cin);
        end
    end

    assign sum_o = t_i ^ carry;
endmodule

// File: rtl/mm_hard_multiple.sv
module mm_hard_multiple
    import hmg_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] x_res,
    input  logic [1:0]   mod_sel,
    output logic [N-1:0] hard_mult
);
    modsel_e      sel;
    gp_t  [N-1:0] bit_gp;
    gp_t  [N-1:0] grp_gp;
    logic [N-1:0] bit_t;

    assign sel = modsel_e'(mod_sel);

    hmg_preproc #(.N(N)) u_pre (
        .x_i   (x_res),
        .sel_i (sel),
        .gp_o  (bit_gp),
        .t_o   (bit_t)
    );

    hmg_prefix_tree #(.N(N)) u_tree (
        .gp_i  (bit_gp),
        .grp_o (grp_gp)
    );

    hmg_postproc #(.N(N)) u_post (
        .t_i   (bit_t),
        .grp_i (grp_gp),
        .sel_i (sel),
        .sum_o (hard_mult)
    );
endmodule

// File: rtl/mm_hard_multiple_chk.sv
module mm_hard_multiple_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] x_res,
    input logic [1:0]   mod_sel,
    input logic [N-1:0] hard_mult
);
    localparam logic [N-1:0] ONES  = '1;
    localparam logic [N-1:0] ZEROS = '0;
    localparam logic [N-1:0] TWO   = N'(2);
    localparam longint       MERS  = (longint'(1) << N) - 1;

    always_comb begin
        if (!$isunknown({x_res, mod_sel})) begin
            if (mod_sel == 2'b01) begin
                AST_POW2_LSB: assert (hard_mult[0] == x_res[0]); // R1
            end
            if (mod_sel == 2'b11) begin
                AST_RSVD_LOW_BITS: assert (hard_mult[1:0] == {x_res[1] ^ x_res[0], x_res[0]}); // R4
            end
            if (mod_sel == 2'b10 && x_res == ZEROS) begin
                AST_MERS_ZERO_IN: assert (hard_mult == ZEROS); // R5
            end
            if (mod_sel == 2'b00 && x_res == ZEROS) begin
                AST_DIM1_ZERO_IN: assert (hard_mult == TWO); // R5
            end
            if (mod_sel == 2'b10 && x_res == ONES) begin
                AST_MERS_ONES_IN: assert (hard_mult == ONES); // R6
            end
            if (mod_sel == 2'b00 && x_res == ONES) begin
                AST_DIM1_ONES_IN: assert (hard_mult == ONES - TWO); // R6
            end
            if (mod_sel == 2'b10 && x_res != ZEROS && ((3 * longint'(x_res)) % MERS) == 0) begin
                AST_MERS_DUAL_ZERO: assert (hard_mult == ONES); // R8
            end
            if (mod_sel == 2'b10) begin
                AST_MERS_NO_FALSE_ZERO: assert (x_res == ZEROS || hard_mult != ZEROS); // R8
            end
        end
    end
endmodule

bind mm_hard_multiple mm_hard_multiple_chk #(.N(N)) u_chk (
    .x_res     (x_res),
    .mod_sel   (mod_sel),
    .hard_mult (hard_mult)
);

// File: tb/mm_hard_multiple_test.sv
module mm_hard_multiple_test;
    localparam int     CLK_PERIOD = 10;
    localparam int     N          = 8;
    localparam longint POW        = longint'(1) << N;
    localparam int     WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic [N-1:0] x_res = '0;
    logic [1:0]   mod_sel = 2'b01;
    logic [N-1:0] hard_mult;

    int checks = 0;
    int fails  = 0;

    mm_hard_multiple #(.N(N)) uut (
        .x_res     (x_res),
        .mod_sel   (mod_sel),
        .hard_mult (hard_mult)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // canonical expected value; for 2^n-1 the residue class in [0, 2^n-2]
    function automatic longint expect_val(input longint xv, input logic [1:0] sv);
        longint r;
        case (sv)
            2'b10:   r = (3 * xv) % (POW - 1);
            2'b00:   r = ((3 * xv + 2) % (POW + 1)) % POW;
            default: r = (3 * xv) % POW;
        endcase
        return r;
    endfunction

    function automatic bit result_ok(input longint xv, input logic [1:0] sv, input longint hv);
        if (sv == 2'b10) return (hv % (POW - 1)) == expect_val(xv, sv);
        return hv == expect_val(xv, sv);
    endfunction

    task automatic judge(input string tag, input logic [N-1:0] xv, input logic [1:0] sv);
        longint hv;
        hv = longint'(hard_mult);
        checks++;
        if (!result_ok(longint'(xv), sv, hv)) begin
            fails++;
            $display("FAIL %s: x=%0d sel=%b actual=%0d expected=%0d", tag, xv, sv, hv,
                     expect_val(longint'(xv), sv));
        end
    endtask

    task automatic exact(input string tag, input logic [N-1:0] want);
        checks++;
        if (hard_mult !== want) begin
            fails++;
            $display("FAIL %s: x=%0d sel=%b actual=%0d expected=%0d", tag, x_res, mod_sel,
                     hard_mult, want);
        end
    endtask

    task automatic apply(input logic [N-1:0] xv, input logic [1:0] sv);
        @(posedge clk);
        x_res   = xv;
        mod_sel = sv;
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [1:0] sv);
        case (sv)
            2'b00:   return "R3";
            2'b01:   return "R1";
            2'b10:   return "R2";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1 - 1);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240917);

        // R5: all-zero operand under each modulus
        apply('0, 2'b01); exact("R5 zero pow2", '0);
        apply('0, 2'b10); exact("R5 zero mers", '0);
        apply('0, 2'b00); exact("R5 zero dim1", N'(2));

        // R6: all-ones operand
        apply('1, 2'b01); exact("R6 ones pow2", N'(POW - 3));
        apply('1, 2'b00); exact("R6 ones dim1", N'(POW - 3));
        apply('1, 2'b10); exact("R6 ones mers", '1);

        // R8: nonzero multiples of 2^n-1 come out all ones
        apply(N'((POW - 1) / 3), 2'b10);     exact("R8 third", '1);
        apply(N'(2 * (POW - 1) / 3), 2'b10); exact("R8 two thirds", '1);

        // R4: reserved code against code 01 on the same operand
        for (int v = 0; v < 16; v++) begin
            logic [N-1:0] ref_out;
            logic [N-1:0] xv;
            xv = N'($urandom());
            apply(xv, 2'b01);
            ref_out = hard_mult;
            apply(xv, 2'b11);
            exact("R4 matches 01", ref_out);
        end

        // exhaustive sweep of every operand under every select code
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < int'(POW); v++) begin
                apply(N'(v), 2'(s));
                judge(tag_of(2'(s)), N'(v), 2'(s));
            end
        end

        // random mix with select changes
        for (int k = 0; k < 300; k++) begin
            logic [N-1:0] xv;
            logic [1:0]   sv;
            xv = N'($urandom());
            sv = 2'($urandom());
            apply(xv, sv);
            judge(tag_of(sv), xv, sv);
        end

        // R7: change inputs between clock edges and sample shortly after
        @(negedge clk);
        #1;
        x_res   = N'(100);
        mod_sel = 2'b00;
        #1;
        judge("R7 mid-cycle dim1", N'(100), 2'b00);
        x_res   = N'(77);
        mod_sel = 2'b10;
        #1;
        judge("R7 mid-cycle mers", N'(77), 2'b10);
        mod_sel = 2'b01;
        #1;
        judge("R7 select only", N'(77), 2'b01);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule